// File: doc/BRIEF.md
# Core Idle-State Controller

This block watches the hardware threads that share one processor core and chooses the core's power state from them. Each thread has a running-or-halted status bit. A halt pulse parks that thread and leaves the others alone. A wake pulse, such as an interrupt, sets a thread running again. While any thread is running, the core stays active. Once every thread has halted, the core clock is gated. If the core then stays idle for a programmable number of cycles, power is also removed.

A wake-up from the power-gated state follows a fixed order. Supply is restored first. A fixed power-good interval then elapses. Only after that is the clock enabled and the woken threads marked running, and at that point the ready flag rises. The state code is two bits wide: active `00`, clock-gated `01`, power-gated `10`. While a restore is in progress the code stays `10`.

Top module: `core_idle_ctrl`

## Requirements
- R1: After reset the state code is `00`, clock enable, power enable and ready are all 1, and all four status bits (`run_o`, bit i for thread i) read 1 (running).
- R2: A halt pulse clears only its own thread's status bit, a halt on an already halted thread changes nothing, and the code stays `00` while at least one thread runs.
- R3: When the last running thread halts in state `00`, the state code is `01` one cycle later, with clock enable 0, power enable 1 and ready 1.
- R4: A halt and a wake for the same thread in the same cycle leave that thread running.
- R5: A wake pulse in state `01` gives state `00` and clock enable 1 one cycle later, and sets only the woken threads' status bits.
- R6: With a nonzero threshold T, the core spends exactly T cycles in state `01` without a wake and then enters state `10`, with clock enable, power enable and ready all 0.
- R7: A threshold of 0 keeps the core in state `01` indefinitely. If the threshold is later raised to a value at or below the cycles already spent idle, the core enters state `10` on the next cycle.
- R8: A wake event clears the residency count, so a later entry into state `01` again needs the full T cycles.
- R9: A wake pulse in state `10` sets power enable one cycle later. Clock enable then stays 0, ready stays 0 and the code stays `10` for 16 cycles, after which the code is `00` and clock enable and ready are 1.
- R10: Halt pulses in state `10`, including during restore, are ignored. On completing the restore, exactly the threads woken since the wake-up began are marked running.
- R11: Clock enable is never 1 while power enable is 0.
- R12: The state code `11` never appears. Any unused internal code returns the core to `00`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| halt_i | input | 4 | Per-thread halt pulse |
| wake_i | input | 4 | Per-thread wake pulse |
| idle_thr_i | input | 16 | Idle cycles in `01` before power gating; 0 disables gating |
| clk_en_o | output | 1 | Core clock enable |
| pwr_en_o | output | 1 | Core power enable |
| state_o | output | 2 | State code: 00 active, 01 clock-gated, 10 power-gated |
| ready_o | output | 1 | Core context usable; low while power-gated or restoring |
| run_o | output | 4 | Per-thread status, 1 = running |

## Verification
Several rules are checked by the assertions on every cycle:
- the power-before-clock ordering;
- the absence of the illegal code;
- the link between the state code and the status bits, where active implies some thread runs and gated implies none does;
- the priority of a wake over a simultaneous halt;
- the clearing of the residency count whenever the core leaves `01`.

The exact idle length T, the counter restart after a wake, the 16-cycle power-good wait and which threads come back after a restore depend on a sequence of events. Only the bench's scenarios can show those, by comparing the ports cycle by cycle with expectations derived from the requirements.

// File: rtl/cis_pkg.sv
package cis_pkg;
   typedef enum logic [1:0] {
      CS_ACTIVE = 2'b00,
      CS_CGATE  = 2'b01,
      CS_PGATE  = 2'b10
   } core_st_e;
endpackage

// File: rtl/cis_thread_track.sv
module cis_thread_track #(
   parameter int NT = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [NT-1:0] halt_i,
   input  logic [NT-1:0] wake_i,
   input  logic          upd_en_i,
   input  logic          collect_i,
   input  logic          commit_i,
   output logic [NT-1:0] run_q_o,
   output logic [NT-1:0] run_nxt_o,
   output logic          wake_any_o
);
   logic [NT-1:0] pend_q;

   assign wake_any_o = |wake_i;

   for (genvar t = 0; t < NT; t++) begin : g_thr
      assign run_nxt_o[t] = wake_i[t] | (run_q_o[t] & ~halt_i[t]);

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            run_q_o[t] <= 1'b1;
            pend_q[t]  <= 1'b0;
         end else if (commit_i) begin
            run_q_o[t] <= pend_q[t] | wake_i[t];
            pend_q[t]  <= 1'b0;
         end else if (collect_i) begin
            pend_q[t]  <= pend_q[t] | wake_i[t];
         end else if (upd_en_i) begin
            run_q_o[t] <= run_nxt_o[t];
         end
      end

      // R4: a wake wins over a halt in the same cycle
      p_wake_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (upd_en_i && !commit_i && wake_i[t]) |=> run_q_o[t]);
   end
endmodule

// File: rtl/cis_residency.sv
module cis_residency #(
   parameter int CW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic [CW-1:0] thr_i,
   output logic          expire_o
);
   logic [CW-1:0] cnt_q;
   logic [CW:0]   cnt_p1;

   assign cnt_p1   = {1'b0, cnt_q} + 1'b1;
   assign expire_o = en_i && (thr_i != '0) && (cnt_p1 >= {1'b0, thr_i});

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !en_i)
         cnt_q <= '0;
      else if (cnt_q != '1)
         cnt_q <= cnt_q + 1'b1;
   end

   // R8: leaving idle residency (or a wake) clears the count
   p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/cis_restore_seq.sv
module cis_restore_seq #(
   parameter int PG = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   initial begin
      assert (PG >= 1) else $error("cis_restore_seq: PG must be at least 1");
   end

   if (PG == 1) begin : g_single
      assign done_o = busy_o;
   end else begin : g_timed
      localparam int TW = $clog2(PG);
      logic [TW-1:0] tmr_q;

      assign done_o = busy_o && (tmr_q == TW'(PG - 1));

      always_ff @(posedge clk_i) begin
         if (!rst_ni || start_i)
            tmr_q <= '0;
         else if (busy_o && !done_o)
            tmr_q <= tmr_q + 1'b1;
      end

      // R9: the timer never passes the power-good length
      p_tmr_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         busy_o |-> (tmr_q <= TW'(PG - 1)));
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         busy_o <= 1'b0;
      else if (start_i)
         busy_o <= 1'b1;
      else if (done_o)
         busy_o <= 1'b0;
   end
endmodule

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl
   import cis_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int THR_W       = 16,
   parameter int PGOOD_CYC   = 16
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [NUM_THREADS-1:0] halt_i,
   input  logic [NUM_THREADS-1:0] wake_i,
   input  logic [THR_W-1:0]       idle_thr_i,
   output logic                   clk_en_o,
   output logic                   pwr_en_o,
   output logic [1:0]             state_o,
   output logic                   ready_o,
   output logic [NUM_THREADS-1:0] run_o
);
   initial begin
      assert (NUM_THREADS >= 1) else $error("core_idle_ctrl: NUM_THREADS must be at least 1");
      assert (THR_W >= 1)       else $error("core_idle_ctrl: THR_W must be at least 1");
   end

   core_st_e                st_q, st_d;
   logic [NUM_THREADS-1:0]  run_nxt;
   logic                    wake_any, expire, rs_busy, rs_done, rs_start;

   assign rs_start = (st_q == CS_PGATE) && !rs_busy && wake_any;

   cis_thread_track #(.NT(NUM_THREADS)) u_track (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .halt_i     (halt_i),
      .wake_i     (wake_i),
      .upd_en_i   ((st_q == CS_ACTIVE) || (st_q == CS_CGATE)),
      .collect_i  (st_q == CS_PGATE),
      .commit_i   (rs_done),
      .run_q_o    (run_o),
      .run_nxt_o  (run_nxt),
      .wake_any_o (wake_any)
   );

   cis_residency #(.CW(THR_W)) u_resid (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     ((st_q == CS_CGATE) && !wake_any),
      .thr_i    (idle_thr_i),
      .expire_o (expire)
   );

   cis_restore_seq #(.PG(PGOOD_CYC)) u_restore (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (rs_start),
      .busy_o  (rs_busy),
      .done_o  (rs_done)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         CS_ACTIVE: if (run_nxt == '0) st_d = CS_CGATE;
         CS_CGATE:  if (wake_any)      st_d = CS_ACTIVE;
                    else if (expire)   st_d = CS_PGATE;
         CS_PGATE:  if (rs_done)       st_d = CS_ACTIVE;
         default:                      st_d = CS_ACTIVE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) st_q <= CS_ACTIVE;
      else         st_q <= st_d;
   end

   assign state_o  = st_q;
   assign clk_en_o = (st_q == CS_ACTIVE);
   assign pwr_en_o = (st_q != CS_PGATE) || rs_busy;
   assign ready_o  = (st_q != CS_PGATE);

   // R11: power must be up whenever the clock runs
   p_clk_needs_pwr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_en_o |-> pwr_en_o);
   // R12: the unused code is never reported
   p_no_illegal_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_o != 2'b11);
   // R2: active state implies at least one running thread
   p_active_has_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == 2'b00) |-> (run_o != '0));
   // R3: gated states hold no running thread
   p_gated_all_halt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o != 2'b00) |-> (run_o == '0));
   // R5: a wake in clock-gated state returns to active next cycle
   p_cgate_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_o == 2'b01) && (wake_i != '0)) |=> (state_o == 2'b00) && clk_en_o);
   // R9: a wake in power-gated state raises power next cycle with clock still off
   p_pwr_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_o == 2'b10) && !pwr_en_o && (wake_i != '0)) |=> pwr_en_o && !clk_en_o);
endmodule

// File: tb/core_idle_ctrl_tb_top.sv
module core_idle_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NT         = 4;
   localparam int PG         = 16;

   typedef struct {
      logic [1:0]    st;
      logic          ce;
      logic          pe;
      logic          rdy;
      logic [NT-1:0] run;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NT-1:0] halt, wake;
   logic [15:0]   thr;
   logic          clk_en, pwr_en, ready;
   logic [1:0]    state;
   logic [NT-1:0] run;

   int   n_chk  = 0;
   int   n_fail = 0;
   bit   saw_bad = 1'b0;
   exp_t  exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   core_idle_ctrl #(.NUM_THREADS(NT), .THR_W(16), .PGOOD_CYC(PG)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .wake_i(wake),
      .idle_thr_i(thr), .clk_en_o(clk_en), .pwr_en_o(pwr_en),
      .state_o(state), .ready_o(ready), .run_o(run)
   );

   task automatic compare(input exp_t e, input string tag);
      n_chk++;
      if (state !== e.st || clk_en !== e.ce || pwr_en !== e.pe ||
          ready !== e.rdy || run !== e.run) begin
         n_fail++;
         $display("FAIL %s: got st=%b ce=%b pe=%b rdy=%b run=%b, expected st=%b ce=%b pe=%b rdy=%b run=%b",
                  tag, state, clk_en, pwr_en, ready, run, e.st, e.ce, e.pe, e.rdy, e.run);
      end
   endtask

   // monitor: compares queued expectations after each active edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n) begin
         if (state === 2'b11 || (clk_en === 1'b1 && pwr_en === 1'b0)) saw_bad = 1'b1;
         if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
      end
   end

   // driver: applies one cycle of stimulus and pushes its expected result
   task automatic tick(input logic [NT-1:0] h, input logic [NT-1:0] w, input bit chk,
                       input logic [1:0] s, input logic c, input logic p, input logic r,
                       input logic [NT-1:0] rn, input string tag);
      exp_t e;
      @(negedge clk);
      halt = h;
      wake = w;
      if (chk) begin
         e.st = s; e.ce = c; e.pe = p; e.rdy = r; e.run = rn;
         exp_q.push_back(e);
         tag_q.push_back(tag);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
   end

   initial begin
      exp_t e0;
      rst_n = 1'b0; halt = '0; wake = '0; thr = 16'd5;
      repeat (3) @(negedge clk);
      e0.st = 2'b00; e0.ce = 1'b1; e0.pe = 1'b1; e0.rdy = 1'b1; e0.run = 4'b1111;
      compare(e0, "R1 in reset");
      rst_n = 1'b1;
      tick('0, '0, 1, 2'b00, 1, 1, 1, 4'b1111, "R1 after reset");
      // R2: single halts
      tick(4'b0001, '0, 1, 2'b00, 1, 1, 1, 4'b1110, "R2 one halt");
      tick(4'b0001, '0, 1, 2'b00, 1, 1, 1, 4'b1110, "R2 repeated halt");
      // R4: halt and wake together
      tick(4'b0110, 4'b0110, 1, 2'b00, 1, 1, 1, 4'b1110, "R4 halt+wake");
      tick(4'b0110, '0, 1, 2'b00, 1, 1, 1, 4'b1000, "R2 two halts");
      // R3: last halt gates clock
      tick(4'b1000, '0, 1, 2'b01, 0, 1, 1, 4'b0000, "R3 last halt");
      // R5: wake from clock gating
      tick('0, 4'b0100, 1, 2'b00, 1, 1, 1, 4'b0100, "R5 wake from 01");
      tick(4'b0100, '0, 1, 2'b01, 0, 1, 1, 4'b0000, "R3 re-enter 01");
      for (int i = 0; i < 3; i++) tick('0, '0, 1, 2'b01, 0, 1, 1, 4'b0000, "R6 residency");
      // R8: wake before threshold clears the count
      tick('0, 4'b0001, 1, 2'b00, 1, 1, 1, 4'b0001, "R8 early wake");
      tick(4'b0001, '0, 1, 2'b01, 0, 1, 1, 4'b0000, "R8 re-enter 01");
      for (int i = 0; i < 4; i++) tick('0, '0, 1, 2'b01, 0, 1, 1, 4'b0000, "R8 full count again");
      tick('0, '0, 1, 2'b10, 0, 0, 0, 4'b0000, "R6 enter 10 after T");
      // R10: halts ignored in power gating
      tick(4'b1111, '0, 1, 2'b10, 0, 0, 0, 4'b0000, "R10 halt in 10");
      tick('0, '0, 1, 2'b10, 0, 0, 0, 4'b0000, "R6 stay 10");
      // R9: staged restore
      tick('0, 4'b0010, 1, 2'b10, 0, 1, 0, 4'b0000, "R9 power first");
      for (int i = 1; i < PG; i++) begin
         if (i == 5) tick(4'b0010, 4'b1000, 1, 2'b10, 0, 1, 0, 4'b0000, "R10 wake/halt in restore");
         else        tick('0, '0, 1, 2'b10, 0, 1, 0, 4'b0000, "R9 power-good wait");
      end
      tick('0, '0, 1, 2'b00, 1, 1, 1, 4'b1010, "R10 restore done");
      // R7: threshold zero disables power gating
      thr = 16'd0;
      tick(4'b1010, '0, 1, 2'b01, 0, 1, 1, 4'b0000, "R3 all halted");
      for (int i = 0; i < 40; i++) tick('0, '0, 1, 2'b01, 0, 1, 1, 4'b0000, "R7 no gating at 0");
      @(negedge clk);
      thr = 16'd1;
      halt = '0; wake = '0;
      exp_q.push_back('{st: 2'b10, ce: 1'b0, pe: 1'b0, rdy: 1'b0, run: 4'b0000});
      tag_q.push_back("R7 raised threshold");
      // R9: restore with all threads woken
      tick('0, 4'b1111, 1, 2'b10, 0, 1, 0, 4'b0000, "R9 power first all");
      for (int i = 1; i < PG; i++) tick('0, '0, 1, 2'b10, 0, 1, 0, 4'b0000, "R9 wait all");
      tick('0, '0, 1, 2'b00, 1, 1, 1, 4'b1111, "R9 restore all");
      tick('0, '0, 0, 2'b00, 0, 0, 0, 4'b0000, "");
      repeat (3) @(negedge clk);
      n_chk++;
      if (saw_bad) begin
         n_fail++;
         $display("FAIL R11/R12: got illegal code or clock without power, expected none");
      end
      summary();
   end
endmodule